// File: doc/BRIEF.md
# SECDED Codec with Byte Merge

This block protects a 64-bit memory word with eight check bits. It is purely combinational and has two paths that work at the same time. The read path takes a word and its stored check bits from memory and forms an eight-bit syndrome. It repairs any single flipped data bit and classifies the result as clean, single error, double error, or three-or-more errors. Two active-low flags and a small error-kind code report that result.

The write path produces check bits for data going to memory. For a partial write, each byte of the outgoing word comes from one of two places. A byte whose keep-enable is set takes the corrected read byte. A byte whose enable is clear takes the new write byte. Check bits are then generated over this merged word. A full write is simply the case where every enable is clear.

The parity-check matrix uses only odd-weight columns. This lets the weight of the syndrome alone separate check-bit errors, double errors and wider errors from correctable data errors.

Top module: `secded_merge_codec`

## Requirements
- R1: Check bit r is the XOR of every data bit whose matrix column has bit r set. Check bits 2 and 3 are inverted (odd parity), so an all-zero word encodes to 8'h0C.
- R2: Data bit d has column H[d]. Bits 0..55 take the 56 weight-3 byte values in ascending numeric order. Bits 56..63 take the eight smallest weight-5 byte values in ascending order.
- R3: `syndrome` equals the check bits generated from `rd_data`, XOR `rd_chk`.
- R4: A zero syndrome gives `error_type` 0, `err_n` and `merr_n` high, `chk_bit_err` low, and `cor_data` equal to `rd_data`.
- R5: A syndrome equal to H[d] flips data bit d only. It gives `error_type` 1, `err_n` low, `merr_n` high and `chk_bit_err` low.
- R6: A syndrome of weight one gives `error_type` 1, `chk_bit_err` high, `err_n` low, `merr_n` high, and leaves `cor_data` equal to `rd_data`.
- R7: A nonzero even-weight syndrome gives `error_type` 2 with both flags low. Data is not altered.
- R8: An odd-weight syndrome of weight three or more that is no data column gives `error_type` 3 with both flags low. `cor_data` is not valid in this case.
- R9: Merged byte i is byte i of `cor_data` when `byte_keep[i]` is 1, otherwise byte i of `wr_data`. `wr_chk` is generated per R1 over the merged word.
- R10: `merr_n` low always implies `err_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rd_data | input | 64 | Data word read from memory |
| rd_chk | input | 8 | Check bits stored with the read word |
| wr_data | input | 64 | New data from the system side |
| byte_keep | input | 8 | Per byte: 1 keeps corrected read byte, 0 takes write byte |
| cor_data | output | 64 | Corrected read data |
| syndrome | output | 8 | Read syndrome |
| wr_chk | output | 8 | Check bits for the merged write word |
| error_type | output | 2 | 0 none, 1 single, 2 double, 3 three or more |
| chk_bit_err | output | 1 | Single error lies in a check bit |
| err_n | output | 1 | Active-low any-error flag |
| merr_n | output | 1 | Active-low uncorrectable-error flag |

## Verification
On every evaluation, the assertions tie the flags and error kind to the syndrome weight. They also check that only a data-column hit changes the data, and that a data repair flips exactly one bit. The bench's scenarios are what show the code itself is right. They cover the column assignment, the odd-parity rows, repair at each of the 64 data positions and each of the 8 check positions, sampled double errors, chosen wider errors, and the byte-merge source and check bits under several enable masks.

// File: rtl/secded_pkg.sv
`timescale 1ns/1ps
package secded_pkg;
  localparam int DATA_W = 64;
  localparam int CHK_W  = 8;
  localparam int BYTE_W = 8;
  localparam int BYTES  = DATA_W / BYTE_W;
  localparam logic [CHK_W-1:0] ODD_ROWS = 8'h0C;

  typedef enum logic [1:0] {
    EK_NONE   = 2'd0,
    EK_SINGLE = 2'd1,
    EK_DOUBLE = 2'd2,
    EK_MULTI  = 2'd3
  } err_kind_e;

  typedef logic [DATA_W-1:0][CHK_W-1:0] hmat_t;

  function automatic int weight_of(input logic [CHK_W-1:0] v);
    int n = 0;
    for (int b = 0; b < CHK_W; b++) n += int'(v[b]);
    return n;
  endfunction

  // odd-weight columns, lightest first, ascending value within a weight
  function automatic hmat_t build_cols();
    hmat_t h = '0;
    int    n = 0;
    for (int w = 3; w <= CHK_W; w += 2) begin
      for (int v = 1; v < (1 << CHK_W); v++) begin
        if (n < DATA_W && weight_of(v[CHK_W-1:0]) == w) begin
          h[n] = v[CHK_W-1:0];
          n++;
        end
      end
    end
    return h;
  endfunction

  localparam hmat_t H_COLS = build_cols();
endpackage

// File: rtl/secded_chkgen.sv
`timescale 1ns/1ps
module secded_chkgen
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);
  for (genvar r = 0; r < CHK_W; r++) begin : g_row
    logic [DATA_W-1:0] taps;
    for (genvar d = 0; d < DATA_W; d++) begin : g_tap
      assign taps[d] = data[d] & H_COLS[d][r];
    end
    assign chk[r] = (^taps) ^ ODD_ROWS[r];
  end
endmodule

// File: rtl/secded_decode.sv
`timescale 1ns/1ps
module secded_decode
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] raw,
  input  logic [CHK_W-1:0]  syn,
  output logic [DATA_W-1:0] fixed,
  output err_kind_e         kind,
  output logic              chk_hit
);
  logic [DATA_W-1:0] hit;

  for (genvar d = 0; d < DATA_W; d++) begin : g_col
    assign hit[d] = (syn == H_COLS[d]);
  end

  assign fixed = raw ^ hit;

  always_comb begin
    chk_hit = 1'b0;
    if (syn == '0) begin
      kind = EK_NONE;
    end else if ($onehot(syn)) begin
      kind    = EK_SINGLE;
      chk_hit = 1'b1;
    end else if (|hit) begin
      kind = EK_SINGLE;
    end else if (!(^syn)) begin
      kind = EK_DOUBLE;
    end else begin
      kind = EK_MULTI;
    end
  end
endmodule

// File: rtl/secded_merge.sv
`timescale 1ns/1ps
module secded_merge
  import secded_pkg::*;
(
  input  logic [DATA_W-1:0] new_word,
  input  logic [DATA_W-1:0] old_word,
  input  logic [BYTES-1:0]  keep_old,
  output logic [DATA_W-1:0] merged
);
  for (genvar i = 0; i < BYTES; i++) begin : g_byte
    assign merged[i*BYTE_W +: BYTE_W] = keep_old[i] ? old_word[i*BYTE_W +: BYTE_W]
                                                    : new_word[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/secded_merge_codec.sv
`timescale 1ns/1ps
module secded_merge_codec
  import secded_pkg::*;
(
  input  logic [63:0] rd_data,
  input  logic [7:0]  rd_chk,
  input  logic [63:0] wr_data,
  input  logic [7:0]  byte_keep,
  output logic [63:0] cor_data,
  output logic [7:0]  syndrome,
  output logic [7:0]  wr_chk,
  output logic [1:0]  error_type,
  output logic        chk_bit_err,
  output logic        err_n,
  output logic        merr_n
);
  logic [CHK_W-1:0]  rd_gen;
  logic [DATA_W-1:0] merged;
  err_kind_e         kind;

  secded_chkgen u_rdgen (.data(rd_data), .chk(rd_gen));

  assign syndrome = rd_gen ^ rd_chk;

  secded_decode u_dec (
    .raw(rd_data), .syn(syndrome), .fixed(cor_data),
    .kind(kind), .chk_hit(chk_bit_err)
  );

  assign error_type = kind;
  assign err_n      = (kind == EK_NONE);
  assign merr_n     = !(kind == EK_DOUBLE || kind == EK_MULTI);

  secded_merge u_mrg (
    .new_word(wr_data), .old_word(cor_data),
    .keep_old(byte_keep), .merged(merged)
  );

  secded_chkgen u_wrgen (.data(merged), .chk(wr_chk));
endmodule

// File: rtl/secded_codec_chk.sv
`timescale 1ns/1ps
module secded_codec_chk (
  input logic [63:0] rd_data,
  input logic [7:0]  rd_chk,
  input logic [63:0] wr_data,
  input logic [7:0]  byte_keep,
  input logic [63:0] cor_data,
  input logic [7:0]  syndrome,
  input logic [7:0]  wr_chk,
  input logic [1:0]  error_type,
  input logic        chk_bit_err,
  input logic        err_n,
  input logic        merr_n
);
  always_comb begin
    AST_CLEAN_PASS: assert (syndrome != 8'h00 ||
      (err_n && merr_n && error_type == 2'd0 && cor_data == rd_data)); // R4
    AST_DATA_ONE_FLIP: assert (!(error_type == 2'd1 && !chk_bit_err) ||
      ($countones(cor_data ^ rd_data) == 1 && !err_n && merr_n)); // R5
    AST_CHKBIT_KEEP: assert (!($countones(syndrome) == 1) ||
      (chk_bit_err && error_type == 2'd1 && cor_data == rd_data)); // R6
    AST_EVEN_IS_DOUBLE: assert (!(syndrome != 8'h00 && !(^syndrome)) ||
      (error_type == 2'd2 && !err_n && !merr_n && cor_data == rd_data)); // R7
    AST_MULTI_FLAGS: assert (error_type != 2'd3 ||
      (!err_n && !merr_n && (^syndrome) && $countones(syndrome) >= 3)); // R8
    AST_FLAG_ORDER: assert (merr_n || !err_n); // R10
  end
endmodule

bind secded_merge_codec secded_codec_chk u_chk (.*);

// File: tb/sim_secded_merge_codec.sv
`timescale 1ns/1ps
module sim_secded_merge_codec;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [63:0] rd_data, wr_data, cor_data;
  logic [7:0]  rd_chk, byte_keep, syndrome, wr_chk;
  logic [1:0]  error_type;
  logic        chk_bit_err, err_n, merr_n;
  int checks = 0;
  int errors = 0;
  logic done = 1'b0;

  secded_merge_codec u0 (.*);

  function automatic int wt(input logic [7:0] v);
    int n = 0;
    for (int b = 0; b < 8; b++) n += int'(v[b]);
    return n;
  endfunction

  // R2 column rule, rebuilt from the requirement text
  function automatic logic [7:0] col(input int idx);
    int n = 0;
    for (int w = 3; w <= 5; w += 2)
      for (int v = 1; v < 256; v++)
        if (wt(v[7:0]) == w) begin
          if (n == idx) return v[7:0];
          n++;
        end
    return 8'h00;
  endfunction

  logic [7:0] cols [64];

  function automatic logic [7:0] enc(input logic [63:0] d);
    logic [7:0] c = 8'h0C;
    for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
    return c;
  endfunction

  function automatic bit is_col(input logic [7:0] s);
    for (int i = 0; i < 64; i++) if (cols[i] == s) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [63:0] rd, input logic [7:0] rc,
                       input logic [63:0] wd, input logic [7:0] bk);
    @(posedge clk);
    #1;
    rd_data = rd; rd_chk = rc; wr_data = wd; byte_keep = bk;
    #2;
  endtask

  task automatic t_idle_state;
    apply(64'h0, 8'h0C, 64'h0, 8'h00);
    chk(wr_chk == 8'h0C, "R1 zero word", wr_chk, 8'h0C);
    chk(err_n && merr_n && error_type == 2'd0, "R4 idle flags", {err_n, merr_n, error_type}, 4'b1100);
  endtask

  task automatic t_encode;
    logic [63:0] pats [4] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h0123_4567_89AB_CDEF,
                              64'h8000_0000_0000_0001, 64'hA5A5_5A5A_0F0F_F0F0};
    for (int k = 0; k < 4; k++) begin
      apply(64'h0, 8'h0C, pats[k], 8'h00);
      chk(wr_chk == enc(pats[k]), "R1 encode", wr_chk, enc(pats[k]));
    end
    for (int i = 0; i < 64; i++) begin
      apply(64'h0, 8'h0C, 64'h1 << i, 8'h00);
      chk((wr_chk ^ 8'h0C) == cols[i], "R2 column", wr_chk ^ 8'h0C, cols[i]);
    end
  endtask

  task automatic t_clean;
    for (int k = 0; k < 6; k++) begin
      logic [63:0] d = {$urandom, $urandom};
      apply(d, enc(d), 64'h0, 8'h00);
      chk(syndrome == 8'h00, "R3 clean syndrome", syndrome, 0);
      chk(cor_data == d && err_n && merr_n && !chk_bit_err && error_type == 2'd0,
          "R4 clean pass", cor_data, d);
    end
  endtask

  task automatic t_single_data;
    for (int i = 0; i < 64; i++) begin
      logic [63:0] d = {$urandom, $urandom};
      apply(d ^ (64'h1 << i), enc(d), 64'h0, 8'h00);
      chk(syndrome == cols[i], "R3 single syndrome", syndrome, cols[i]);
      chk(cor_data == d, "R5 corrected data", cor_data, d);
      chk(error_type == 2'd1 && !err_n && merr_n && !chk_bit_err, "R5 flags",
          {error_type, err_n, merr_n, chk_bit_err}, 5'b01010);
    end
  endtask

  task automatic t_single_chk;
    for (int j = 0; j < 8; j++) begin
      logic [63:0] d = {$urandom, $urandom};
      apply(d, enc(d) ^ (8'h1 << j), 64'h0, 8'h00);
      chk(syndrome == (8'h1 << j), "R6 syndrome", syndrome, 8'h1 << j);
      chk(cor_data == d && chk_bit_err && error_type == 2'd1 && !err_n && merr_n,
          "R6 check-bit error", cor_data, d);
    end
  endtask

  task automatic t_double;
    for (int k = 0; k < 120; k++) begin
      int a = $urandom_range(71, 0);
      int b = $urandom_range(71, 0);
      logic [63:0] d = {$urandom, $urandom};
      logic [71:0] cw;
      if (a == b) b = (a + 1) % 72;
      cw = {enc(d), d};
      cw[a] = ~cw[a];
      cw[b] = ~cw[b];
      apply(cw[63:0], cw[71:64], 64'h0, 8'h00);
      chk(error_type == 2'd2 && !err_n && !merr_n, "R7 double flags",
          {error_type, err_n, merr_n}, 4'b1000);
      chk(cor_data == cw[63:0], "R7 no alteration", cor_data, cw[63:0]);
      chk(!merr_n -> !err_n, "R10 flag order", {err_n, merr_n}, 2'b00);
    end
  endtask

  task automatic t_multi;
    int found = 0;
    for (int k = 0; k < 4000 && found < 20; k++) begin
      int a = $urandom_range(63, 0);
      int b = $urandom_range(63, 0);
      int c = $urandom_range(63, 0);
      logic [7:0] s;
      if (a == b || b == c || a == c) continue;
      s = cols[a] ^ cols[b] ^ cols[c];
      if (wt(s) >= 3 && !is_col(s)) begin
        logic [63:0] d = {$urandom, $urandom};
        found++;
        apply(d ^ (64'h1 << a) ^ (64'h1 << b) ^ (64'h1 << c), enc(d), 64'h0, 8'h00);
        chk(syndrome == s, "R3 triple syndrome", syndrome, s);
        chk(error_type == 2'd3 && !err_n && !merr_n, "R8 multiple flags",
            {error_type, err_n, merr_n}, 4'b1100);
      end
    end
    chk(found > 0, "R8 patterns found", found, 1);
  endtask

  task automatic t_merge;
    logic [7:0] masks [5] = '{8'h00, 8'hFF, 8'h0F, 8'hA5, 8'h81};
    for (int k = 0; k < 5; k++) begin
      logic [63:0] rd = {$urandom, $urandom};
      logic [63:0] wd = {$urandom, $urandom};
      logic [63:0] m;
      int flip = $urandom_range(63, 0);
      for (int i = 0; i < 8; i++) m[i*8 +: 8] = masks[k][i] ? rd[i*8 +: 8] : wd[i*8 +: 8];
      apply(rd ^ (64'h1 << flip), enc(rd), wd, masks[k]);
      chk(wr_chk == enc(m), "R9 merged check bits", wr_chk, enc(m));
    end
  endtask

  initial begin
    rd_data = '0; rd_chk = 8'h0C; wr_data = '0; byte_keep = '0;
    for (int i = 0; i < 64; i++) cols[i] = col(i);
    t_idle_state();
    t_encode();
    t_clean();
    t_single_data();
    t_single_chk();
    t_double();
    t_multi();
    t_merge();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule